// File: doc/BRIEF.md
# Legacy Display Memory Steering Decoder

This block watches memory cycle addresses and picks out those that land in the 128 KB legacy display window, 000A_0000h through 000B_FFFFh. Each such cycle is sent to exactly one of three destinations: the on-chip graphics engine, a downstream bridge port, or the default legacy interface. The decision comes from fixed priority rules and three configuration bits. These are a graphics-claim bit, a display-forwarding enable, and a flag that says a separate monochrome adapter sits behind the legacy interface.

The window has three fixed slices. The low colour slice runs from 000A_0000h to 000A_FFFFh. The monochrome slice runs from 000B_0000h to 000B_7FFFh. The high colour slice runs from 000B_8000h to 000B_FFFFh. The on-chip graphics engine always takes precedence over everything else. When it does not claim the window, the forwarding enable and the monochrome flag choose between the downstream port and the legacy interface. The result is registered, so it appears one clock after the request.

Top module: `legacy_disp_steer`

## Requirements
- R1: While `rst` is high, and on the first clock after reset, `in_window` is 0 and `target` is 3'b000, whatever the inputs are.
- R2: The outputs respond to the request sampled at one rising edge of `clk` and show the result after that same edge, so the latency is one clock.
- R3: A request with `req_valid` low, or with an address below 000A_0000h or above 000B_FFFFh, produces `in_window` = 0 and `target` = 3'b000.
- R4: Whenever `in_window` is 1, exactly one bit of `target` is set. The bit meanings are: bit 0 is the graphics engine, bit 1 is the downstream port, and bit 2 is the legacy interface.
- R5: When `gfx_claim` is 1, every valid in-window address is steered to the graphics engine (`target` = 3'b001), whatever `vga_fwd_en` and `mono_present` are set to.
- R6: When `gfx_claim` is 0 and `vga_fwd_en` is 1, addresses in the low colour slice (000A_0000h–000A_FFFFh) and the high colour slice (000B_8000h–000B_FFFFh) go to the downstream port (`target` = 3'b010).
- R7: When `gfx_claim` is 0, `vga_fwd_en` is 1 and `mono_present` is 1, addresses in the monochrome slice (000B_0000h–000B_7FFFh) go to the legacy interface (`target` = 3'b100).
- R8: When `gfx_claim` is 0, `vga_fwd_en` is 1 and `mono_present` is 0, addresses in the monochrome slice go to the downstream port (`target` = 3'b010).
- R9: When `gfx_claim` is 0 and `vga_fwd_en` is 0, the whole window goes to the legacy interface (`target` = 3'b100), whatever `mono_present` is set to.
- R10: The slice edges are inclusive. 000A_FFFFh and 000B_0000h fall in different slices, and so do 000B_7FFFh and 000B_8000h. 0009_FFFFh and 000C_0000h fall outside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A memory cycle address is presented |
| req_addr | input | 32 | Memory cycle address |
| gfx_claim | input | 1 | The on-chip graphics engine owns the window |
| vga_fwd_en | input | 1 | Forward the colour slices to the downstream port |
| mono_present | input | 1 | A monochrome adapter sits behind the legacy interface |
| in_window | output | 1 | Registered: the last request hit the window |
| target | output | 3 | Registered one-hot destination (0 graphics, 1 downstream, 2 legacy) |

## Verification
Two steering rules can apply to the same request. The monochrome split wants the monochrome slice to go to the legacy interface, and the graphics claim wants the whole window to go to the graphics engine. The bench sets `gfx_claim` and `mono_present` together and sends addresses at both edges of the monochrome slice. The result counts as correct only if the graphics engine wins. The bench also enables the forwarding bit and the monochrome flag together, then alternates addresses across the 000B_7FFFh/000B_8000h boundary on consecutive cycles. This shows that the split and the downstream routing switch cleanly from one clock to the next.

// File: rtl/lgw_pkg.sv
package lgw_pkg;
  localparam int NUM_SLICE = 3;
  localparam int NUM_TGT   = 3;

  typedef enum logic [1:0] {
    SL_LOCOLOR = 2'd0,
    SL_MONO    = 2'd1,
    SL_HICOLOR = 2'd2
  } slice_e;

  localparam int TGT_GFX  = 0;
  localparam int TGT_DOWN = 1;
  localparam int TGT_LEG  = 2;

  typedef struct packed {
    logic gfx_claim;
    logic vga_fwd_en;
    logic mono_present;
  } steer_cfg_t;
endpackage

// File: rtl/lgw_slice_match.sv
module lgw_slice_match #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LOC_LO = 'h000A_0000,
  parameter logic [ADDR_W-1:0] MONO_LO = 'h000B_0000,
  parameter logic [ADDR_W-1:0] HIC_LO = 'h000B_8000,
  parameter logic [ADDR_W-1:0] HIC_HI = 'h000B_FFFF
) (
  input  logic                          valid,
  input  logic [ADDR_W-1:0]             addr,
  output logic [lgw_pkg::NUM_SLICE-1:0] hit,
  output logic                          any_hit
);
  import lgw_pkg::*;

  localparam logic [ADDR_W-1:0] LOC_HI  = MONO_LO - 1'b1;
  localparam logic [ADDR_W-1:0] MONO_HI = HIC_LO - 1'b1;
  localparam logic [NUM_SLICE-1:0][ADDR_W-1:0] LO_TAB = {HIC_LO, MONO_LO, LOC_LO};
  localparam logic [NUM_SLICE-1:0][ADDR_W-1:0] HI_TAB = {HIC_HI, MONO_HI, LOC_HI};

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
    assign hit[s] = valid && (addr >= LO_TAB[s]) && (addr <= HI_TAB[s]);
  end

  assign any_hit = |hit;

  // R10
  slice_exclusive_chk: assert final ($onehot0(hit));
endmodule

// File: rtl/lgw_route.sv
module lgw_route (
  input  logic [lgw_pkg::NUM_SLICE-1:0] hit,
  input  logic                          any_hit,
  input  lgw_pkg::steer_cfg_t           cfg,
  output logic [lgw_pkg::NUM_TGT-1:0]   tgt
);
  import lgw_pkg::*;

  always_comb begin
    tgt = '0;
    if (any_hit) begin
      if (cfg.gfx_claim)
        tgt[TGT_GFX] = 1'b1;
      else if (!cfg.vga_fwd_en)
        tgt[TGT_LEG] = 1'b1;
      else if (hit[SL_MONO] && cfg.mono_present)
        tgt[TGT_LEG] = 1'b1;
      else
        tgt[TGT_DOWN] = 1'b1;
    end
  end
endmodule

// File: rtl/lgw_out_reg.sv
module lgw_out_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit_d,
  input  logic [W-1:0] tgt_d,
  output logic         hit_q,
  output logic [W-1:0] tgt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      hit_q <= hit_d;
      tgt_q <= tgt_d;
    end
  end

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $onehot(tgt_q));
  // R3
  idle_no_target_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (tgt_q == '0));
endmodule

// File: rtl/legacy_disp_steer.sv
module legacy_disp_steer #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LOC_LO  = 'h000A_0000,
  parameter logic [ADDR_W-1:0] MONO_LO = 'h000B_0000,
  parameter logic [ADDR_W-1:0] HIC_LO  = 'h000B_8000,
  parameter logic [ADDR_W-1:0] HIC_HI  = 'h000B_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              gfx_claim,
  input  logic              vga_fwd_en,
  input  logic              mono_present,
  output logic              in_window,
  output logic [2:0]        target
);
  import lgw_pkg::*;

  logic [NUM_SLICE-1:0] hit;
  logic                 any_hit;
  logic [NUM_TGT-1:0]   tgt_d;
  steer_cfg_t           cfg;

  assign cfg = '{gfx_claim: gfx_claim, vga_fwd_en: vga_fwd_en, mono_present: mono_present};

  lgw_slice_match #(
    .ADDR_W(ADDR_W), .LOC_LO(LOC_LO), .MONO_LO(MONO_LO), .HIC_LO(HIC_LO), .HIC_HI(HIC_HI)
  ) i_match (
    .valid(req_valid), .addr(req_addr), .hit(hit), .any_hit(any_hit)
  );

  lgw_route i_route (.hit(hit), .any_hit(any_hit), .cfg(cfg), .tgt(tgt_d));

  lgw_out_reg #(.W(NUM_TGT)) i_oreg (
    .clk(clk), .rst(rst), .hit_d(any_hit), .tgt_d(tgt_d),
    .hit_q(in_window), .tgt_q(target)
  );

  // R2 R3
  win_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (in_window == ($past(req_valid) &&
      $past(req_addr) >= LOC_LO && $past(req_addr) <= HIC_HI)));
  // R5
  gfx_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gfx_claim) && in_window) |-> (target == 3'b001));
  // R9
  all_legacy_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(gfx_claim) && !$past(vga_fwd_en) && in_window) |-> (target == 3'b100));
  // R7
  mono_split_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(gfx_claim) && $past(vga_fwd_en) && $past(mono_present) && in_window &&
     $past(req_addr) >= MONO_LO && $past(req_addr) < HIC_LO) |-> (target == 3'b100));
  // R6
  color_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(gfx_claim) && $past(vga_fwd_en) && in_window &&
     ($past(req_addr) < MONO_LO || $past(req_addr) >= HIC_LO)) |-> (target == 3'b010));
endmodule

// File: tb/test_legacy_disp_steer.sv
module test_legacy_disp_steer;
  typedef struct {
    logic       win;
    logic [2:0] tgt;
    string      req;
    logic [31:0] addr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        gfx_claim = 1'b0;
  logic        vga_fwd_en = 1'b0;
  logic        mono_present = 1'b0;
  logic        in_window;
  logic [2:0]  target;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  legacy_disp_steer i_legacy_disp_steer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .gfx_claim(gfx_claim), .vga_fwd_en(vga_fwd_en), .mono_present(mono_present),
    .in_window(in_window), .target(target)
  );

  function automatic void check(string req, logic [3:0] act, logic [3:0] exp, logic [31:0] a);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual win/tgt=%b expected=%b", req, a, act, exp);
    end
  endfunction

  // independent reference built from the requirement text
  function automatic exp_t model(logic v, logic [31:0] a, logic g, logic f, logic m);
    exp_t e;
    e.addr = a;
    e.win = v && a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
    if (!e.win) begin e.tgt = 3'b000; e.req = "R3"; end
    else if (g) begin e.tgt = 3'b001; e.req = "R5"; end
    else if (!f) begin e.tgt = 3'b100; e.req = "R9"; end
    else if (a >= 32'h000B_0000 && a <= 32'h000B_7FFF) begin
      e.tgt = m ? 3'b100 : 3'b010; e.req = m ? "R7" : "R8";
    end else begin e.tgt = 3'b010; e.req = "R6"; end
    return e;
  endfunction

  task automatic drive(logic v, logic [31:0] a, logic g, logic f, logic m, string tag = "");
    exp_t e;
    @(negedge clk);
    req_valid = v; req_addr = a; gfx_claim = g; vga_fwd_en = f; mono_present = m;
    e = model(v, a, g, f, m);
    if (tag != "") e.req = {e.req, " ", tag};
    sb.push_back(e);
  endtask

  // monitor: result visible just after the edge that samples the request (R2)
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.req, " R2 R4"}, {in_window, target}, {e.win, e.tgt}, e.addr);
    end
  end

  initial begin
    logic [31:0] edges [10];
    edges = '{32'h0009_FFFF, 32'h000A_0000, 32'h000A_FFFF, 32'h000B_0000, 32'h000B_7FFF,
              32'h000B_8000, 32'h000B_FFFF, 32'h000C_0000, 32'h100A_0000, 32'h000A_4000};
    req_valid = 1'b1; req_addr = 32'h000A_0000; gfx_claim = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", {in_window, target}, 4'b0000, req_addr);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 after reset", {in_window, target}, 4'b0000, req_addr);
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 10; i++)
        drive(1'b1, edges[i], c[2], c[1], c[0], "R10");
    // invalid in-window request ignored
    drive(1'b0, 32'h000A_8000, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 32'h000B_2000, 1'b1, 1'b0, 1'b1);
    // graphics claim together with monochrome split
    drive(1'b1, 32'h000B_0000, 1'b1, 1'b1, 1'b1, "overlap");
    drive(1'b1, 32'h000B_7FFF, 1'b1, 1'b1, 1'b1, "overlap");
    // back-to-back switching across the mono/high-colour edge
    for (int k = 0; k < 6; k++)
      drive(1'b1, k[0] ? 32'h000B_8000 : 32'h000B_7FFF, 1'b0, 1'b1, 1'b1, "b2b");
    drive(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule